// File: doc/BRIEF.md
# Packed Floating-Point Pairwise Add/Subtract Unit

This block operates on two 128-bit packed floating-point operands. It returns one 128-bit packed result, chosen by a 3-bit operation code. It has three kinds of operation. The interleaved kind works lane by lane between the two operands: even lanes subtract and odd lanes add. The pairwise-sum kind adds neighbouring lanes that sit inside the same operand. The pairwise-difference kind subtracts neighbouring lanes inside the same operand. Each kind runs either on four 32-bit single-precision lanes or on two 64-bit double-precision lanes, all in the same 128-bit word.

In the pairwise kinds, the results that come from operand A fill the low half of the output word and the results from operand B fill the high half. Every subtraction flips the sign of the second operand and then feeds it to a shared floating-point adder. That adder uses simplified arithmetic: it truncates, flushes denormals to zero, and returns one fixed quiet-NaN pattern.

Data enters through a valid/ready input and leaves through a one-entry registered valid/ready output. A transfer happens on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty, or when the output register is being drained in that same cycle. While `out_valid` is high and `out_ready` is low, the output word must not change. Lane 0 always sits in the least significant bits.

Top module: `hsimd_hadd_unit`

## Requirements
- R1: Op code 3'b000 (single interleaved) gives lane i = A_i − B_i for even i and A_i + B_i for odd i, with four 32-bit lanes.
- R2: Op code 3'b001 (double interleaved) gives lane 0 = A0 − B0 and lane 1 = A1 + B1, with two 64-bit lanes.
- R3: Op code 3'b010 (single pairwise sum) gives lanes 0..3 = A0+A1, A2+A3, B0+B1, B2+B3.
- R4: Op code 3'b100 (single pairwise difference) gives lanes 0..3 = A0−A1, A2−A3, B0−B1, B2−B3. The lower-indexed lane is always the minuend.
- R5: Op code 3'b011 gives lanes A0+A1 and B0+B1. Op code 3'b101 gives lanes A0−A1 and B0−B1 (double precision, A result in lane 0).
- R6: Op codes 3'b110 and 3'b111 return operand A unchanged.
- R7: Results are truncated toward zero. A magnitude that overflows saturates to the largest finite value of the same sign.
- R8: Denormal inputs count as zero, and results below the smallest normal become zero. A sum of two zeros is negative only when both zeros are negative. An arithmetic result is never denormal.
- R9: An infinity input passes through to the output. A NaN input, or the sum of two infinities with opposite signs, gives the quiet NaN 0x7FC00000 (single) or 0x7FF8000000000000 (double).
- R10: An accepted input shows up on `out_valid`/`out_data` after exactly one rising clock edge. A synchronous active-low reset clears `out_valid`.
- R11: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_data` holds its value. A draining cycle with no new input clears `out_valid`.
- R12: Two equal operands that cancel exactly give +0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word is valid |
| in_ready | output | 1 | Unit can take an input this cycle |
| in_op | input | 3 | Operation code; bit 0 selects double precision |
| in_a | input | 128 | Packed operand A, lane 0 in the low bits |
| in_b | input | 128 | Packed operand B, lane 0 in the low bits |
| out_valid | output | 1 | Output register holds a result |
| out_ready | input | 1 | Downstream takes the result this cycle |
| out_data | output | 128 | Packed result |

## Verification
The assertions check the handshake on every cycle: an accepted word produces a full output register, a stalled output stays frozen, and a drain with no new input empties the register. On every single-precision lane the assertions also check that an adder output is never denormal and that every NaN it emits is the canonical quiet NaN. Only the bench scenarios can show that lanes are paired, ordered and signed correctly for each of the eight op codes, that truncation and saturation give the right bit patterns, and that reset in the middle of a stall empties the register.

// File: rtl/hsimd_pkg.sv
`timescale 1ns/1ps
package hsimd_pkg;

  // Operation kind, taken from in_op[2:1]; in_op[0] picks double precision.
  typedef enum logic [1:0] {
    KIND_ADDSUB = 2'd0,
    KIND_HADD   = 2'd1,
    KIND_HSUB   = 2'd2,
    KIND_PASS   = 2'd3
  } hs_kind_e;

  function automatic hs_kind_e op_kind(input logic [2:0] op);
    return hs_kind_e'(op[2:1]);
  endfunction

  function automatic logic op_is_double(input logic [2:0] op);
    return op[0];
  endfunction

endpackage

// File: rtl/hsimd_lane_router.sv
`timescale 1ns/1ps
// Picks the two adder operands for every lane of one precision and applies
// the sign flip that turns the shared adder into a subtractor.
module hsimd_lane_router
  import hsimd_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int LANE_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  hs_kind_e          kind,
  output logic [DATA_W-1:0] x,
  output logic [DATA_W-1:0] y
);
  localparam int NLANE = DATA_W / LANE_W;
  localparam int HALF  = NLANE / 2;

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    logic [LANE_W-1:0] pair_lo, pair_hi, x_l, y_raw;
    logic              neg;

    // Pairwise kinds: low output lanes come from A, high lanes from B.
    if (i < HALF) begin : g_from_a
      assign pair_lo = a[(2*i)*LANE_W   +: LANE_W];
      assign pair_hi = a[(2*i+1)*LANE_W +: LANE_W];
    end else begin : g_from_b
      assign pair_lo = b[(2*(i-HALF))*LANE_W   +: LANE_W];
      assign pair_hi = b[(2*(i-HALF)+1)*LANE_W +: LANE_W];
    end

    always_comb begin
      if (kind == KIND_ADDSUB) begin
        x_l   = a[i*LANE_W +: LANE_W];
        y_raw = b[i*LANE_W +: LANE_W];
        neg   = ((i % 2) == 0);          // even lanes subtract
      end else begin
        x_l   = pair_lo;
        y_raw = pair_hi;
        neg   = (kind == KIND_HSUB);     // lower lane is the minuend
      end
    end

    assign x[i*LANE_W +: LANE_W] = x_l;
    assign y[i*LANE_W +: LANE_W] = {y_raw[LANE_W-1] ^ neg, y_raw[LANE_W-2:0]};
  end

endmodule

// File: rtl/hsimd_fp_add.sv
`timescale 1ns/1ps
// Simplified IEEE-754 adder: truncating rounding, denormals flushed to zero,
// infinities passed through, one canonical quiet NaN.
module hsimd_fp_add #(
  parameter int EW = 8,
  parameter int MW = 23
) (
  input  logic [EW+MW:0] a,
  input  logic [EW+MW:0] b,
  output logic [EW+MW:0] y
);
  localparam int N    = EW + MW + 1;
  localparam int W    = MW + 4;             // hidden bit, fraction, 3 extra
  localparam int EMAX = (1 << EW) - 1;
  localparam logic [N-1:0] QNAN = {1'b0, {EW{1'b1}}, 1'b1, {(MW-1){1'b0}}};

  logic          sa, sb, sx, sy;
  logic [EW-1:0] ea, eb, ex, ey;
  logic [MW-1:0] fa, fb, fx, fy;
  logic          a_zero, b_zero, a_inf, b_inf, a_nan, b_nan, swap, hit;
  logic [W-1:0]  mxw, myw, mys, diff, norm;
  logic [W:0]    sum;
  int            d, e, lz;

  always_comb begin
    sa = a[N-1]; ea = a[N-2:MW]; fa = a[MW-1:0];
    sb = b[N-1]; eb = b[N-2:MW]; fb = b[MW-1:0];
    a_zero = (ea == '0);
    b_zero = (eb == '0);
    a_inf  = (ea == '1) && (fa == '0);
    b_inf  = (eb == '1) && (fb == '0);
    a_nan  = (ea == '1) && (fa != '0);
    b_nan  = (eb == '1) && (fb != '0);

    // Put the larger magnitude in x.
    swap = {eb, fb} > {ea, fa};
    sx = swap ? sb : sa;  ex = swap ? eb : ea;  fx = swap ? fb : fa;
    sy = swap ? sa : sb;  ey = swap ? ea : eb;  fy = swap ? fa : fb;

    d   = int'(ex) - int'(ey);
    mxw = {1'b1, fx, 3'b000};
    myw = {1'b1, fy, 3'b000};
    if (d >= W) begin
      mys    = '0;
      mys[0] = 1'b1;
    end else begin
      mys = myw >> d;
      if ((myw & ((W'(1) << d) - W'(1))) != '0) mys[0] = 1'b1;   // sticky
    end

    sum  = '0;
    diff = '0;
    norm = '0;
    lz   = 0;
    hit  = 1'b0;
    e    = int'(ex);
    if (sx == sy) begin
      sum = {1'b0, mxw} + {1'b0, mys};
      if (sum[W]) begin
        norm = sum[W:1];
        e    = e + 1;
      end else begin
        norm = sum[W-1:0];
      end
    end else begin
      diff = mxw - mys;
      for (int k = W - 1; k >= 0; k--) begin
        if (!hit && diff[k]) begin
          lz  = W - 1 - k;
          hit = 1'b1;
        end
      end
      norm = diff << lz;
      e    = e - lz;
    end

    if (a_nan || b_nan || (a_inf && b_inf && (sa != sb))) y = QNAN;
    else if (a_inf)                                       y = a;
    else if (b_inf)                                       y = b;
    else if (a_zero && b_zero)                            y = {sa & sb, {(N-1){1'b0}}};
    else if (a_zero)                                      y = b;
    else if (b_zero)                                      y = a;
    else if ((sx != sy) && !hit)                          y = '0;  // exact cancel: +0
    else if (e <= 0)                                      y = {sx, {(N-1){1'b0}}};
    else if (e >= EMAX)                                   y = {sx, EW'(EMAX - 1), {MW{1'b1}}};
    else                                                  y = {sx, EW'(e), norm[W-2:3]};
  end

endmodule

// File: rtl/hsimd_hadd_unit.sv
`timescale 1ns/1ps
module hsimd_hadd_unit
  import hsimd_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int SP_EW  = 8,
  parameter int SP_MW  = 23,
  parameter int DP_EW  = 11,
  parameter int DP_MW  = 52
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_op,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  localparam int SP_W = SP_EW + SP_MW + 1;
  localparam int DP_W = DP_EW + DP_MW + 1;
  localparam int SP_N = DATA_W / SP_W;
  localparam int DP_N = DATA_W / DP_W;
  localparam logic [SP_W-1:0] SP_QNAN = {1'b0, {SP_EW{1'b1}}, 1'b1, {(SP_MW-1){1'b0}}};

  hs_kind_e          kind;
  logic              dbl, accept;
  logic [DATA_W-1:0] sp_x, sp_y, dp_x, dp_y, sp_res, dp_res, res;

  assign kind = op_kind(in_op);
  assign dbl  = op_is_double(in_op);

  hsimd_lane_router #(.DATA_W(DATA_W), .LANE_W(SP_W)) u_route_sp (
    .a(in_a), .b(in_b), .kind(kind), .x(sp_x), .y(sp_y)
  );
  hsimd_lane_router #(.DATA_W(DATA_W), .LANE_W(DP_W)) u_route_dp (
    .a(in_a), .b(in_b), .kind(kind), .x(dp_x), .y(dp_y)
  );

  for (genvar i = 0; i < SP_N; i++) begin : g_sp
    hsimd_fp_add #(.EW(SP_EW), .MW(SP_MW)) u_add (
      .a(sp_x[i*SP_W +: SP_W]), .b(sp_y[i*SP_W +: SP_W]), .y(sp_res[i*SP_W +: SP_W])
    );

    // Adder output is never denormal.
    p_no_denorm_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sp_res[i*SP_W+SP_MW +: SP_EW] == '0) |-> (sp_res[i*SP_W +: SP_MW] == '0));

    // Any NaN the adder produces is the canonical quiet NaN.
    p_qnan_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((sp_res[i*SP_W+SP_MW +: SP_EW] == '1) && (sp_res[i*SP_W +: SP_MW] != '0))
        |-> (sp_res[i*SP_W +: SP_W] == SP_QNAN));
  end

  for (genvar j = 0; j < DP_N; j++) begin : g_dp
    hsimd_fp_add #(.EW(DP_EW), .MW(DP_MW)) u_add (
      .a(dp_x[j*DP_W +: DP_W]), .b(dp_y[j*DP_W +: DP_W]), .y(dp_res[j*DP_W +: DP_W])
    );
  end

  always_comb begin
    if (kind == KIND_PASS) res = in_a;
    else if (dbl)          res = dp_res;
    else                   res = sp_res;
  end

  // One-entry output register with valid/ready on both sides.
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) out_data <= res;
  end

  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_drain_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

endmodule

// File: tb/hsimd_hadd_unit_bench.sv
`timescale 1ns/1ps
module hsimd_hadd_unit_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid, in_ready, out_valid, out_ready;
  logic [2:0]   in_op;
  logic [127:0] in_a, in_b, out_data;
  int           n_chk = 0;
  int           n_bad = 0;

  always #4 clk = ~clk;   // 125 MHz

  hsimd_hadd_unit u_hsimd_hadd_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  function automatic logic [31:0] sp_of(input int v);
    int m, p;
    logic [31:0] r;
    if (v == 0) return 32'h0;
    m = (v < 0) ? -v : v;
    p = 0;
    for (int i = 0; i < 31; i++) if ((m >> i) != 0) p = i;
    r[31]    = (v < 0);
    r[30:23] = 8'(127 + p);
    r[22:0]  = 23'(m << (23 - p));
    return r;
  endfunction

  function automatic logic [63:0] dp_of(input longint v);
    longint m;
    int p;
    logic [63:0] r;
    if (v == 0) return 64'h0;
    m = (v < 0) ? -v : v;
    p = 0;
    for (int i = 0; i < 63; i++) if ((m >> i) != 0) p = i;
    r[63]    = (v < 0);
    r[62:52] = 11'(1023 + p);
    r[51:0]  = 52'(m << (52 - p));
    return r;
  endfunction

  // One transfer with the sink ready; result checked one edge later (R10).
  task automatic run(input logic [2:0] op, input logic [127:0] a, input logic [127:0] b,
                     input logic [127:0] exp, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && (out_data === exp), tag, out_data, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [127:0] e0, e1;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; in_op = 3'b000; in_a = '0; in_b = '0;
    repeat (3) @(negedge clk);
    check(!out_valid && in_ready, "R10 reset state", {126'b0, out_valid, in_ready}, 128'h1);
    rst_n = 1'b1;

    // Sweep every op code over many integer-valued lane patterns.
    for (int op = 0; op < 8; op++) begin
      for (int k = 0; k < 40; k++) begin
        int av[4], bv[4];
        logic [127:0] A, B, E;
        string tag;
        for (int i = 0; i < 4; i++) begin
          av[i] = ((k * 7 + i * 13) % 41) - 20;
          bv[i] = ((k * 11 + i * 5 + op) % 37) - 18;
        end
        if (op[0] && op < 6) begin
          A = {dp_of(av[1]), dp_of(av[0])};
          B = {dp_of(bv[1]), dp_of(bv[0])};
        end else begin
          A = {sp_of(av[3]), sp_of(av[2]), sp_of(av[1]), sp_of(av[0])};
          B = {sp_of(bv[3]), sp_of(bv[2]), sp_of(bv[1]), sp_of(bv[0])};
        end
        case (op)
          0: begin E = {sp_of(av[3]+bv[3]), sp_of(av[2]-bv[2]), sp_of(av[1]+bv[1]), sp_of(av[0]-bv[0])}; tag = "R1 single interleaved"; end
          1: begin E = {dp_of(av[1]+bv[1]), dp_of(av[0]-bv[0])}; tag = "R2 double interleaved"; end
          2: begin E = {sp_of(bv[2]+bv[3]), sp_of(bv[0]+bv[1]), sp_of(av[2]+av[3]), sp_of(av[0]+av[1])}; tag = "R3 single pair sum"; end
          3: begin E = {dp_of(bv[0]+bv[1]), dp_of(av[0]+av[1])}; tag = "R5 double pair sum"; end
          4: begin E = {sp_of(bv[2]-bv[3]), sp_of(bv[0]-bv[1]), sp_of(av[2]-av[3]), sp_of(av[0]-av[1])}; tag = "R4 single pair diff"; end
          5: begin E = {dp_of(bv[0]-bv[1]), dp_of(av[0]-av[1])}; tag = "R5 double pair diff"; end
          default: begin E = A; tag = "R6 pass A"; end
        endcase
        run(3'(op), A, B, E, tag);
      end
    end

    // R12: exact cancellation gives +0.
    run(3'b100, {sp_of(-7), sp_of(-7), sp_of(5), sp_of(5)}, '0, 128'h0, "R12 single cancel");
    run(3'b101, {dp_of(-9), dp_of(-9)}, {dp_of(3), dp_of(3)}, 128'h0, "R12 double cancel");

    // R7: truncation and saturation.
    run(3'b000, {64'h0, 32'h3F800000, 32'h3F800000}, {64'h0, 32'h30800000, 32'h30800000},
        {64'h0, 32'h3F800000, 32'h3F7FFFFF}, "R7 single truncation");
    run(3'b010, {32'hFF7FFFFF, 32'hFF7FFFFF, 32'h7F7FFFFF, 32'h7F7FFFFF}, '0,
        {64'h0, 32'hFF7FFFFF, 32'h7F7FFFFF}, "R7 single saturation");
    run(3'b001, {64'h0, 64'h3FF0000000000000}, {64'h0, 64'h3C30000000000000},
        {64'h0, 64'h3FEFFFFFFFFFFFFF}, "R7 double truncation");

    // R8: denormal flush and underflow.
    run(3'b010, {32'h80800000, 32'h00800001, 32'h40000000, 32'h00000001},
        {32'h807FFFFF, 32'h807FFFFF, 64'h0},
        {32'h80000000, 32'h00000000, 32'h00000000, 32'h40000000}, "R8 flush to zero");

    // R9: infinities and NaN.
    run(3'b010, {32'hFF800000, 32'h7F800000, 32'h3F800000, 32'h7F800000},
        {32'h40000000, 32'hFF800000, 32'h00000000, 32'h7F800001},
        {32'hFF800000, 32'h7FC00000, 32'h7FC00000, 32'h7F800000}, "R9 single specials");
    run(3'b011, {64'hFFF0000000000000, 64'h7FF0000000000000},
        {64'h7FF0000000000000, 64'h3FF0000000000000},
        {64'h7FF0000000000000, 64'h7FF8000000000000}, "R9 double specials");

    // R10: nothing visible before the edge, result after exactly one edge.
    @(negedge clk);
    in_valid = 1'b1; in_op = 3'b010; out_ready = 1'b1;
    in_a = {sp_of(4), sp_of(3), sp_of(2), sp_of(1)}; in_b = '0;
    #1;
    check(!out_valid, "R10 no early valid", {127'b0, out_valid}, 128'h0);
    @(negedge clk);
    in_valid = 1'b0;
    e0 = {64'h0, sp_of(7), sp_of(3)};
    check(out_valid && out_data === e0, "R10 one-cycle latency", out_data, e0);

    // R11: back-pressure holds the result and blocks input.
    @(negedge clk);
    in_valid = 1'b1; in_op = 3'b010; out_ready = 1'b0;
    in_a = {sp_of(1), sp_of(1), sp_of(2), sp_of(2)}; in_b = '0;
    e0 = {64'h0, sp_of(2), sp_of(4)};
    @(negedge clk);
    check(out_valid && !in_ready, "R11 stall blocks input", {126'b0, out_valid, in_ready}, 128'h2);
    in_a = {sp_of(10), sp_of(10), sp_of(10), sp_of(10)};
    @(negedge clk);
    check(out_valid && out_data === e0, "R11 held while stalled", out_data, e0);
    out_ready = 1'b1;
    e1 = {64'h0, sp_of(20), sp_of(20)};
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_data === e1, "R11 drain with refill", out_data, e1);
    @(negedge clk);
    check(!out_valid, "R11 drain empties", {127'b0, out_valid}, 128'h0);

    // R10: reset clears a stalled result.
    in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(!out_valid, "R10 reset clears valid", {127'b0, out_valid}, 128'h0);
    rst_n = 1'b1; out_ready = 1'b1;
    @(negedge clk);

    report();
  end

endmodule